// File: doc/BRIEF.md
# Tagged Capability Memory Access Checker

This block stands between a load/store unit and a small local memory built from 128-bit granules. Every granule carries one hidden validity bit that marks it as holding a genuine capability rather than plain bytes. Each request names an access kind, a byte address, the decoded authority it runs under (base, length, permission bits, sealed flag and that authority's own validity bit), and whether the target page is flagged as a capability page. The block answers one cycle later with either read data or a trap and a cause code.

Before any memory state changes, the request passes an ordered series of checks: bounds, permissions, sealing, page type and authority validity. Only a request that clears every check may read or write. Granule validity bits cannot be reached as data. Only a capability store can set one, and any plain store into a granule clears its bit. Capability loads hand the bit back next to the 128-bit value, so untagged bytes always come back marked as plain data.

Top module: `capmem_guard`

## Requirements
- R1: Each 128-bit granule owns one validity bit, and reset clears all of them. A capability load of any granule after reset returns tag 0.
- R2: A plain load (kind 0) returns the 32-bit word at address bits [3:2] of the granule, zero-extended into rsp_data, and rsp_tag is 0.
- R3: A capability store (kind 3) writes all 128 data bits and the validity bit (from req_wtag) on one clock edge. A following capability load (kind 2) returns both together. No other kind can set a validity bit.
- R4: A plain store (kind 1) writes only the 32-bit word selected by address bits [3:2], taken from req_wdata[31:0], and clears that granule's validity bit. The other words are unchanged.
- R5: An access is in bounds only when (req_addr − auth_base), taken modulo 2^ADDR_W, is less than auth_len as an unsigned compare. Otherwise the cause is 1 (bounds).
- R6: Permission bits are: bit 0 load, bit 1 store, bit 2 load-capability, bit 3 store-capability. Kinds 0 and 2 need bit 0, kinds 1 and 3 need bit 1, kind 2 also needs bit 2 and kind 3 also needs bit 3. A missing bit gives cause 2.
- R7: Any access under a sealed authority traps with cause 3.
- R8: When page_cap is 1, a plain load or store (kinds 0 and 1) traps with cause 4. Capability kinds are unaffected by page_cap.
- R9: An authority whose auth_tag is 0 traps with cause 5.
- R10: When several causes apply, the lowest-numbered one is reported (bounds 1, permission 2, sealed 3, page 4, untagged authority 5). Cause 0 means no trap.
- R11: A trapped request changes no data and no validity bit, and its response carries rsp_data 0 and rsp_tag 0.
- R12: Every request with req_vld high produces exactly one response with rsp_vld high on the next cycle. rsp_trap is 1 exactly when rsp_cause is nonzero.
- R13: A capability load from a granule whose validity bit is 0 returns its 128 data bits with rsp_tag 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 plain load, 1 plain store, 2 capability load, 3 capability store |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 128 | Store data (plain stores use bits [31:0]) |
| req_wtag | input | 1 | Validity bit of the capability being stored |
| auth_base | input | ADDR_W | Decoded lower bound of the authority |
| auth_len | input | ADDR_W+1 | Decoded length of the authority |
| auth_perm | input | 4 | Authority permission bits |
| auth_sealed | input | 1 | Authority is sealed |
| auth_tag | input | 1 | Authority validity bit |
| page_cap | input | 1 | Target page is a capability page |
| rsp_vld | output | 1 | Response present |
| rsp_data | output | 128 | Read data |
| rsp_tag | output | 1 | Validity bit returned by a capability load |
| rsp_trap | output | 1 | Request trapped |
| rsp_cause | output | 3 | Trap cause code |

## Verification
Directed requests reach the exact bounds edges: the last byte inside, the first byte past the end, and an address below the base that wraps. They also exercise each missing permission bit on its own, and combinations of causes that show which one wins. Store-then-load sequences tell whether a plain store clears a set validity bit without disturbing the other words, and whether a trapped capability store leaves the granule alone. A long seeded random stream mixes all four kinds with skewed permission, seal, page and authority-validity rates. It is compared against a bench model of the data and validity bits, so ordering faults and stale-bit faults show up in later loads.

// File: rtl/capmem_pkg.sv
package capmem_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD     = 2'd0,
        ACC_STORE    = 2'd1,
        ACC_CAPLOAD  = 2'd2,
        ACC_CAPSTORE = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        TRAP_NONE   = 3'd0,
        TRAP_BOUNDS = 3'd1,
        TRAP_PERM   = 3'd2,
        TRAP_SEALED = 3'd3,
        TRAP_CPAGE  = 3'd4,
        TRAP_NOAUTH = 3'd5
    } trap_e;

    localparam int PERM_W   = 4;
    localparam int P_LOAD   = 0;
    localparam int P_STORE  = 1;
    localparam int P_LDCAP  = 2;
    localparam int P_STCAP  = 3;

    localparam int LANE_W   = 32;
    localparam int LANES    = 4;
    localparam int GRAN_W   = LANE_W * LANES;
    localparam int LSEL_W   = $clog2(LANES);
    localparam int OFS_W    = $clog2(GRAN_W / 8);

    typedef struct packed {
        trap_e     cause;
        acc_kind_e kind;
        logic      wr_en;
        logic      wr_full;
    } verdict_t;

    function automatic logic is_cap(acc_kind_e k);
        return (k == ACC_CAPLOAD) || (k == ACC_CAPSTORE);
    endfunction

    function automatic logic is_write(acc_kind_e k);
        return (k == ACC_STORE) || (k == ACC_CAPSTORE);
    endfunction

    function automatic logic [PERM_W-1:0] needed_perms(acc_kind_e k);
        logic [PERM_W-1:0] m;
        m = '0;
        unique case (k)
            ACC_LOAD:     m[P_LOAD] = 1'b1;
            ACC_STORE:    m[P_STORE] = 1'b1;
            ACC_CAPLOAD:  begin m[P_LOAD] = 1'b1; m[P_LDCAP] = 1'b1; end
            ACC_CAPSTORE: begin m[P_STORE] = 1'b1; m[P_STCAP] = 1'b1; end
            default:      m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/capmem_check.sv
module capmem_check
    import capmem_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  acc_kind_e          kind,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [ADDR_W-1:0]  base,
    input  logic [ADDR_W:0]    len,
    input  logic [PERM_W-1:0]  perm,
    input  logic               sealed,
    input  logic               auth_ok,
    input  logic               page_cap,
    output trap_e              cause
);
    logic [ADDR_W-1:0] offset;
    logic              in_range;
    logic              perm_ok;

    assign offset   = addr - base;
    assign in_range = {1'b0, offset} < len;
    assign perm_ok  = (needed_perms(kind) & ~perm) == '0;

    always_comb begin
        if (!in_range)
            cause = TRAP_BOUNDS;
        else if (!perm_ok)
            cause = TRAP_PERM;
        else if (sealed)
            cause = TRAP_SEALED;
        else if (page_cap && !is_cap(kind))
            cause = TRAP_CPAGE;
        else if (!auth_ok)
            cause = TRAP_NOAUTH;
        else
            cause = TRAP_NONE;
    end
endmodule

// File: rtl/capmem_tagstore.sv
module capmem_tagstore
    import capmem_pkg::*;
#(
    parameter int IDX_W = 6,
    localparam int GRAN_N = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LSEL_W-1:0] lane,
    input  logic              wr_en,
    input  logic              wr_full,
    input  logic [GRAN_W-1:0] wdata,
    input  logic              wtag,
    output logic [GRAN_W-1:0] rdata,
    output logic              rtag
);
    logic [GRAN_N-1:0] valid_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] cells [GRAN_N];
        logic [LANE_W-1:0] rd_q;
        logic              hit;

        assign hit = wr_en && (wr_full || (lane == LSEL_W'(l)));

        always_ff @(posedge clk) begin
            if (hit)
                cells[idx] <= wdata[l*LANE_W +: LANE_W];
            rd_q <= cells[idx];
        end

        assign rdata[l*LANE_W +: LANE_W] = rd_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            rtag    <= 1'b0;
        end else begin
            if (wr_en)
                valid_q[idx] <= wr_full ? wtag : 1'b0;
            rtag <= valid_q[idx];
        end
    end
endmodule

// File: rtl/capmem_guard.sv
module capmem_guard
    import capmem_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_vld,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [127:0]      req_wdata,
    input  logic              req_wtag,
    input  logic [ADDR_W-1:0] auth_base,
    input  logic [ADDR_W:0]   auth_len,
    input  logic [3:0]        auth_perm,
    input  logic              auth_sealed,
    input  logic              auth_tag,
    input  logic              page_cap,
    output logic              rsp_vld,
    output logic [127:0]      rsp_data,
    output logic              rsp_tag,
    output logic              rsp_trap,
    output logic [2:0]        rsp_cause
);
    localparam int IDX_W = ADDR_W - OFS_W;

    acc_kind_e         kind;
    trap_e             cause_w;
    verdict_t          v;
    verdict_t          v_q;
    logic              rsp_vld_q;
    logic [LSEL_W-1:0] lane_q;
    logic [GRAN_W-1:0] st_data;
    logic [GRAN_W-1:0] rd_data;
    logic              rd_tag;

    assign kind = acc_kind_e'(req_kind);

    capmem_check #(.ADDR_W(ADDR_W)) u_check (
        .kind     (kind),
        .addr     (req_addr),
        .base     (auth_base),
        .len      (auth_len),
        .perm     (auth_perm),
        .sealed   (auth_sealed),
        .auth_ok  (auth_tag),
        .page_cap (page_cap),
        .cause    (cause_w)
    );

    always_comb begin
        v.cause   = cause_w;
        v.kind    = kind;
        v.wr_en   = req_vld && (cause_w == TRAP_NONE) && is_write(kind);
        v.wr_full = (kind == ACC_CAPSTORE);
    end

    assign st_data = v.wr_full ? req_wdata : {LANES{req_wdata[LANE_W-1:0]}};

    capmem_tagstore #(.IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .idx     (req_addr[ADDR_W-1:OFS_W]),
        .lane    (req_addr[OFS_W-1:OFS_W-LSEL_W]),
        .wr_en   (v.wr_en),
        .wr_full (v.wr_full),
        .wdata   (st_data),
        .wtag    (req_wtag && v.wr_full),
        .rdata   (rd_data),
        .rtag    (rd_tag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld_q <= 1'b0;
            v_q       <= '0;
            lane_q    <= '0;
        end else begin
            rsp_vld_q <= req_vld;
            lane_q    <= req_addr[OFS_W-1:OFS_W-LSEL_W];
            if (req_vld)
                v_q <= v;
            else
                v_q <= '0;
        end
    end

    always_comb begin
        rsp_data = '0;
        rsp_tag  = 1'b0;
        if (rsp_vld_q && v_q.cause == TRAP_NONE) begin
            if (v_q.kind == ACC_LOAD)
                rsp_data[LANE_W-1:0] = rd_data[lane_q*LANE_W +: LANE_W];
            else if (v_q.kind == ACC_CAPLOAD) begin
                rsp_data = rd_data;
                rsp_tag  = rd_tag;
            end
        end
    end

    assign rsp_vld   = rsp_vld_q;
    assign rsp_trap  = rsp_vld_q && (v_q.cause != TRAP_NONE);
    assign rsp_cause = rsp_vld_q ? v_q.cause : TRAP_NONE;
endmodule

// File: rtl/capmem_guard_sva.sv
module capmem_guard_sva #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              req_vld,
    input logic [1:0]        req_kind,
    input logic [ADDR_W-1:0] req_addr,
    input logic [127:0]      req_wdata,
    input logic              req_wtag,
    input logic [ADDR_W-1:0] auth_base,
    input logic [ADDR_W:0]   auth_len,
    input logic [3:0]        auth_perm,
    input logic              auth_sealed,
    input logic              auth_tag,
    input logic              page_cap,
    input logic              rsp_vld,
    input logic [127:0]      rsp_data,
    input logic              rsp_tag,
    input logic              rsp_trap,
    input logic [2:0]        rsp_cause
);
    logic [ADDR_W-1:0] span;
    logic              outside;

    assign span    = req_addr - auth_base;
    assign outside = !({1'b0, span} < auth_len);

    // R12
    resp_follows_chk: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> rsp_vld);

    // R12
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_vld |=> !rsp_vld);

    // R5
    bounds_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (req_vld && outside) |=> (rsp_cause == 3'd1));

    // R7
    sealed_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (req_vld && auth_sealed) |=> rsp_trap);

    // R8
    cpage_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (req_vld && page_cap && !req_kind[1]) |=> rsp_trap);

    // R9
    noauth_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (req_vld && !auth_tag) |=> rsp_trap);

    // R2
    plain_tagless_chk: assert property (@(posedge clk) disable iff (rst)
        (req_vld && req_kind != 2'd2) |=> !rsp_tag);

    // R11
    trap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_trap |-> (rsp_data == '0 && !rsp_tag));

    // R10
    cause_legal_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_cause <= 3'd5);
endmodule

bind capmem_guard capmem_guard_sva #(.ADDR_W(ADDR_W)) u_sva (.*);

// File: tb/sim_capmem_guard.sv
`timescale 1ns/1ps
module sim_capmem_guard;
    localparam int AW = 10;
    localparam int NG = 1 << (AW - 4);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           req_vld = 1'b0;
    logic [1:0]     req_kind = '0;
    logic [AW-1:0]  req_addr = '0;
    logic [127:0]   req_wdata = '0;
    logic           req_wtag = 1'b0;
    logic [AW-1:0]  auth_base = '0;
    logic [AW:0]    auth_len = '0;
    logic [3:0]     auth_perm = '0;
    logic           auth_sealed = 1'b0;
    logic           auth_tag = 1'b0;
    logic           page_cap = 1'b0;
    logic           rsp_vld;
    logic [127:0]   rsp_data;
    logic           rsp_tag;
    logic           rsp_trap;
    logic [2:0]     rsp_cause;

    int checks = 0;
    int fails  = 0;

    logic [127:0] mdat [NG];
    logic         mtag [NG];

    always #2 clk = ~clk;

    capmem_guard #(.ADDR_W(AW)) u0 (.*);

    function automatic logic [2:0] exp_cause(logic [1:0] k, logic [AW-1:0] a,
            logic [AW-1:0] b, logic [AW:0] l, logic [3:0] p, logic s,
            logic t, logic pg);
        logic [AW-1:0] d;
        logic [3:0]    need;
        d = a - b;
        need = 4'b0;
        need[k[0] ? 1 : 0] = 1'b1;
        if (k == 2'd2) need[2] = 1'b1;
        if (k == 2'd3) need[3] = 1'b1;
        if (!({1'b0, d} < l)) return 3'd1;
        if ((need & ~p) != 0) return 3'd2;
        if (s) return 3'd3;
        if (pg && !k[1]) return 3'd4;
        if (!t) return 3'd5;
        return 3'd0;
    endfunction

    task automatic check(string req, logic ok, string what,
                         logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_req(logic [1:0] k, logic [AW-1:0] a, logic [127:0] wd,
            logic wt, logic [AW-1:0] b, logic [AW:0] l, logic [3:0] p,
            logic s, logic t, logic pg, logic cmp_data, string req);
        logic [2:0]   ec;
        logic [127:0] ed;
        logic         et;
        int           g;
        int           ln;
        g  = int'(a[AW-1:4]);
        ln = int'(a[3:2]);
        ec = exp_cause(k, a, b, l, p, s, t, pg);
        ed = '0;
        et = 1'b0;
        if (ec == 0) begin
            if (k == 2'd0) ed[31:0] = mdat[g][ln*32 +: 32];
            if (k == 2'd2) begin ed = mdat[g]; et = mtag[g]; end
        end
        req_vld = 1'b1; req_kind = k; req_addr = a; req_wdata = wd;
        req_wtag = wt; auth_base = b; auth_len = l; auth_perm = p;
        auth_sealed = s; auth_tag = t; page_cap = pg;
        @(negedge clk);
        req_vld = 1'b0;
        check(req, rsp_vld == 1'b1 && rsp_trap == (ec != 0) && rsp_cause == ec
              && rsp_tag == et && (!cmp_data || rsp_data == ed),
              "vld/trap/cause/tag/data",
              {rsp_vld, rsp_trap, rsp_cause, rsp_tag, cmp_data ? rsp_data[114:0] : 115'd0},
              {1'b1, ec != 0, ec, et, cmp_data ? ed[114:0] : 115'd0});
        if (ec == 0) begin
            if (k == 2'd1) begin mdat[g][ln*32 +: 32] = wd[31:0]; mtag[g] = 1'b0; end
            if (k == 2'd3) begin mdat[g] = wd; mtag[g] = wt; end
        end
    endtask

    localparam logic [AW:0] FULL = (AW+1)'(1 << AW);

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NG; i++) begin mdat[i] = '0; mtag[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12: idle after reset
        check("R12", rsp_vld == 1'b0 && rsp_trap == 1'b0, "reset idle",
              {126'd0, rsp_vld, rsp_trap}, 128'd0);
        // R1: validity bits clear after reset (data not yet defined)
        for (int i = 0; i < NG; i += 9)
            do_req(2'd2, AW'(i*16), '0, 1'b0, '0, FULL, 4'hF, 1'b0, 1'b1, 1'b0, 1'b0, "R1");
        // fill memory so data becomes defined (R13 follows from tag 0)
        for (int i = 0; i < NG; i++)
            do_req(2'd3, AW'(i*16), {4{32'(i) ^ 32'hA5A5_0000}}, 1'b0,
                   '0, FULL, 4'hF, 1'b0, 1'b1, 1'b0, 1'b1, "R3");
        // R13: untagged granule returns data with tag 0
        do_req(2'd2, AW'(5*16), '0, 1'b0, '0, FULL, 4'hF, 1'b0, 1'b1, 1'b0, 1'b1, "R13");
        // R3: capability store with tag, then load
        do_req(2'd3, AW'(3*16), 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 1'b1,
               '0, FULL, 4'hF, 1'b0, 1'b1, 1'b0, 1'b1, "R3");
        do_req(2'd2, AW'(3*16), '0, 1'b0, '0, FULL, 4'hF, 1'b0, 1'b1, 1'b0, 1'b1, "R3");
        // R2: plain load of word 2 of granule 3
        do_req(2'd0, AW'(3*16+8), '0, 1'b0, '0, FULL, 4'hF, 1'b0, 1'b1, 1'b0, 1'b1, "R2");
        // R4: plain store to word 1 clears tag, keeps other words
        do_req(2'd1, AW'(3*16+4), 128'hDEAD_BEEF, 1'b0, '0, FULL, 4'hF, 1'b0, 1'b1, 1'b0, 1'b1, "R4");
        do_req(2'd2, AW'(3*16), '0, 1'b0, '0, FULL, 4'hF, 1'b0, 1'b1, 1'b0, 1'b1, "R4");
        // R5: bounds edges base=0x100 len=0x40
        do_req(2'd0, AW'('h13C), '0, 1'b0, AW'('h100), 11'h40, 4'hF, 1'b0, 1'b1, 1'b0, 1'b1, "R5");
        do_req(2'd0, AW'('h140), '0, 1'b0, AW'('h100), 11'h40, 4'hF, 1'b0, 1'b1, 1'b0, 1'b1, "R5");
        do_req(2'd0, AW'('h0FC), '0, 1'b0, AW'('h100), 11'h40, 4'hF, 1'b0, 1'b1, 1'b0, 1'b1, "R5");
        // R6: missing load-capability, missing store
        do_req(2'd2, AW'('h20), '0, 1'b0, '0, FULL, 4'b1011, 1'b0, 1'b1, 1'b0, 1'b1, "R6");
        do_req(2'd1, AW'('h20), 128'h1, 1'b0, '0, FULL, 4'b1101, 1'b0, 1'b1, 1'b0, 1'b1, "R6");
        do_req(2'd3, AW'('h20), 128'h1, 1'b1, '0, FULL, 4'b0111, 1'b0, 1'b1, 1'b0, 1'b1, "R6");
        // R7: sealed authority
        do_req(2'd0, AW'('h20), '0, 1'b0, '0, FULL, 4'hF, 1'b1, 1'b1, 1'b0, 1'b1, "R7");
        // R8: capability page blocks plain load, not capability load
        do_req(2'd0, AW'('h30), '0, 1'b0, '0, FULL, 4'hF, 1'b0, 1'b1, 1'b1, 1'b1, "R8");
        do_req(2'd2, AW'('h30), '0, 1'b0, '0, FULL, 4'hF, 1'b0, 1'b1, 1'b1, 1'b1, "R8");
        // R9 and R11: untagged authority store leaves granule untouched
        do_req(2'd3, AW'(7*16), {4{32'hFFFF_FFFF}}, 1'b1, '0, FULL, 4'hF, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
        do_req(2'd2, AW'(7*16), '0, 1'b0, '0, FULL, 4'hF, 1'b0, 1'b1, 1'b0, 1'b1, "R11");
        // R10: priority
        do_req(2'd3, AW'('h200), 128'h5, 1'b1, '0, 11'h10, 4'h0, 1'b1, 1'b0, 1'b1, 1'b1, "R10");
        do_req(2'd0, AW'('h8), '0, 1'b0, '0, FULL, 4'h0, 1'b1, 1'b0, 1'b1, 1'b1, "R10");
        do_req(2'd1, AW'('h8), 128'h5, 1'b0, '0, FULL, 4'hF, 1'b1, 1'b0, 1'b1, 1'b1, "R10");
        // random mix checked against model (R12 and all causes)
        for (int n = 0; n < 3000; n++) begin
            logic [AW-1:0] b;
            logic [AW:0]   l;
            logic [AW-1:0] a;
            logic [3:0]    p;
            b = AW'($urandom);
            l = (AW+1)'($urandom % 400);
            a = b + AW'($urandom % 440) - AW'(20);
            p = ($urandom % 4 == 0) ? 4'($urandom) : 4'hF;
            do_req(2'($urandom), a, {$urandom, $urandom, $urandom, $urandom},
                   1'($urandom), b, l, p, ($urandom % 8 == 0),
                   ($urandom % 8 != 0), ($urandom % 4 == 0), 1'b1, "R12");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule